// File: doc/BRIEF.md
# Reset Configuration Word Loader

This block builds a 64-bit configuration word while the rest of the device stays in reset. Once the word is complete, the block holds it on a stable output. A 3-bit mode code is read on the first clock after reset is released, and it picks how the word is built.

In the pin-multiplexed mode the word arrives over a 16-bit pin bus in four passes. The block pulls one of four active-low lane selects low at a time. External logic answers by putting the matching 16-bit quarter of the word on the pins. Each lane is held for a programmable number of settle cycles, and the pins are sampled on the last of them.

In the reduced mode only the low 16 bits come from the pins, in one sample. The upper 48 bits come from a fixed constant. Any other mode code leaves the word at its full default value and raises an error flag. A done flag marks the word as valid and stays high until the next reset.

Top module: `cfgword_loader`

## Requirements
- R1: While reset is held, all lane selects are high (inactive), done and the error flag are low, and the word output equals the full default constant DEF_WORD.
- R2: The mode code is read only on the first clock edge after reset is released. Later changes to it have no effect on the lane selects, the word or the flags.
- R3: The lane selects are active-low and never more than one is low at a time. None is low before or after a pin-multiplexed load.
- R4: With mode code 3'b000 the lane selects go low one at a time, in order: lane 0 (bit 0) first, then lanes 1, 2 and 3. The first lane goes low on the first clock after reset release, and each lane stays low for SETTLE cycles. Lane k's pins are captured into word bits [16k+15:16k] on the last cycle of that lane.
- R5: In the pin-multiplexed mode, done rises on the clock that captures lane 3, which is clock number 1+4*SETTLE after reset release. Done stays high until reset.
- R6: While done is high, the word output does not change, whatever the pins do.
- R7: With mode code 3'b011 the pins are sampled once, on the first clock after reset release. The word becomes {RED_UPPER, pins}, done rises on that same clock, and no lane select is driven low.
- R8: Any mode code other than 3'b000 and 3'b011 leaves the word at DEF_WORD. Done and the error flag both rise on the first clock after reset release.
- R9: The error flag stays low in both supported modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; a new load starts when it is released |
| src_sel | input | 3 | Mode code, read on the first clock after reset release |
| pin_bus | input | 16 | Configuration pins |
| lane_sel_n | output | 4 | Active-low, one-hot lane selects |
| cfg_word | output | 64 | Assembled configuration word |
| done | output | 1 | Word is complete and valid |
| src_err | output | 1 | Mode code was not supported |

## Verification
The bench builds the loader with SETTLE set to 3. Each lane's window is therefore short enough to check cycle by cycle, yet long enough to tell a one-cycle hold from a full one. It also replaces DEF_WORD and RED_UPPER with its own constants, so that a word taken from the wrong source shows up as a mismatch. An external responder drives a different pin pattern for each lane and a third pattern when no lane is selected. A capture from the wrong lane, at the wrong moment or into the wrong quarter of the word therefore changes the result.

// File: rtl/cfgword_loader.sv
module cfgword_loader #(
  parameter int SLICE_W = 16,
  parameter int LANES   = 4,
  parameter int SETTLE  = 4,
  parameter logic [SLICE_W*LANES-1:0] DEF_WORD  = 64'h0000_1F40_8000_0C21,
  parameter logic [SLICE_W*(LANES-1)-1:0] RED_UPPER = 48'h0000_1F40_8000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               src_sel,
  input  logic [SLICE_W-1:0]       pin_bus,
  output logic [LANES-1:0]         lane_sel_n,
  output logic [SLICE_W*LANES-1:0] cfg_word,
  output logic                     done,
  output logic                     src_err
);
  localparam int WORD_W = SLICE_W * LANES;
  localparam int CNT_W  = $clog2(SETTLE + 1);
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [2:0] SRC_MUX = 3'b000;
  localparam logic [2:0] SRC_RED = 3'b011;

  typedef enum logic [1:0] {ST_DECODE, ST_MUX, ST_DONE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  settle;
  logic [IDX_W-1:0]  lane_idx;
  logic [WORD_W-1:0] word_q;
  logic [LANES-1:0]  lane_q;

  wire last_settle = (settle == CNT_W'(SETTLE - 1));
  wire last_lane   = (lane_idx == IDX_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_DECODE;
      settle   <= '0;
      lane_idx <= '0;
      word_q   <= DEF_WORD;
      lane_q   <= '0;
      done     <= 1'b0;
      src_err  <= 1'b0;
    end else begin
      case (st)
        ST_DECODE: begin
          if (src_sel == SRC_MUX) begin
            st       <= ST_MUX;
            settle   <= '0;
            lane_idx <= '0;
            lane_q   <= LANES'(1);
          end else if (src_sel == SRC_RED) begin
            word_q <= {RED_UPPER, pin_bus};
            done   <= 1'b1;
            st     <= ST_DONE;
          end else begin
            src_err <= 1'b1;
            done    <= 1'b1;
            st      <= ST_DONE;
          end
        end
        ST_MUX: begin
          if (last_settle) begin
            word_q[int'(lane_idx)*SLICE_W +: SLICE_W] <= pin_bus;
            settle <= '0;
            if (last_lane) begin
              lane_q <= '0;
              done   <= 1'b1;
              st     <= ST_DONE;
            end else begin
              lane_idx <= lane_idx + 1'b1;
              lane_q   <= lane_q << 1;
            end
          end else begin
            settle <= settle + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign lane_sel_n = ~lane_q;
  assign cfg_word   = word_q;

  a_r3_lane_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lane_sel_n));

  a_r3_lanes_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_sel_n == {LANES{1'b1}}));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(cfg_word));

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |-> done);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> src_err);

  genvar k;
  generate
    for (k = 1; k < LANES; k++) begin : g_order
      a_r4_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_sel_n[k]) |-> $past(!lane_sel_n[k-1]));
    end
  endgenerate
endmodule

// File: tb/cfgword_loader_tb.sv
`timescale 1ns/1ps
module cfgword_loader_tb;
  localparam int S = 3;
  localparam logic [63:0] TB_DEF = 64'h5A5A_0F0F_3C3C_9669;
  localparam logic [47:0] TB_RED = 48'hC001_D00D_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = 3'b000;
  logic [15:0] pin_bus;
  logic [3:0]  lane_sel_n;
  logic [63:0] cfg_word;
  logic        done, src_err;

  logic        resp_on = 1'b0;
  logic [63:0] resp_pat = '0;
  logic [15:0] pin_static = 16'h7777;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    case (lane_sel_n)
      4'b1110: pin_bus = resp_on ? resp_pat[15:0]  : pin_static;
      4'b1101: pin_bus = resp_on ? resp_pat[31:16] : pin_static;
      4'b1011: pin_bus = resp_on ? resp_pat[47:32] : pin_static;
      4'b0111: pin_bus = resp_on ? resp_pat[63:48] : pin_static;
      default: pin_bus = pin_static;
    endcase
  end

  cfgword_loader #(.SETTLE(S), .DEF_WORD(TB_DEF), .RED_UPPER(TB_RED)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pin_bus(pin_bus),
    .lane_sel_n(lane_sel_n), .cfg_word(cfg_word), .done(done), .src_err(src_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    src_sel = code;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(lane_sel_n == 4'hF, "R1 lanes", 64'(lane_sel_n), 64'hF);
    chk(done == 1'b0, "R1 done", 64'(done), 64'h0);
    chk(src_err == 1'b0, "R1 err", 64'(src_err), 64'h0);
    chk(cfg_word == TB_DEF, "R1 word", cfg_word, TB_DEF);
  endtask

  task automatic t_mux(input logic [63:0] pat, input bit swap_src);
    resp_on = 1'b1;
    resp_pat = pat;
    start(3'b000);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < S; j++) begin
        @(negedge clk);
        chk(lane_sel_n == ~(4'b0001 << k), "R4 lane order/hold", 64'(lane_sel_n), 64'(~(4'b0001 << k)));
        chk(done == 1'b0, "R5 done early", 64'(done), 64'h0);
        if (swap_src && k == 0 && j == 0) src_sel = 3'b011;
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R5 done rise", 64'(done), 64'h1);
    chk(cfg_word == pat, "R4 word assembled", cfg_word, pat);
    chk(lane_sel_n == 4'hF, "R3 lanes idle", 64'(lane_sel_n), 64'hF);
    chk(src_err == 1'b0, "R9 err mux", 64'(src_err), 64'h0);
    if (swap_src) chk(cfg_word == pat, "R2 late src ignored", cfg_word, pat);
    resp_pat = ~pat;
    pin_static = 16'h1234;
    src_sel = 3'b111;
    repeat (5) @(negedge clk);
    chk(cfg_word == pat, "R6 word held", cfg_word, pat);
    chk(done == 1'b1, "R5 done sticky", 64'(done), 64'h1);
    chk(src_err == 1'b0, "R2 err stays low", 64'(src_err), 64'h0);
  endtask

  task automatic t_reduced(input logic [15:0] pins);
    resp_on = 1'b0;
    pin_static = pins;
    start(3'b011);
    @(negedge clk);
    chk(done == 1'b1, "R7 done", 64'(done), 64'h1);
    chk(cfg_word == {TB_RED, pins}, "R7 word", cfg_word, {TB_RED, pins});
    chk(lane_sel_n == 4'hF, "R7 no lanes", 64'(lane_sel_n), 64'hF);
    chk(src_err == 1'b0, "R9 err reduced", 64'(src_err), 64'h0);
    pin_static = ~pins;
    src_sel = 3'b000;
    repeat (4) @(negedge clk);
    chk(cfg_word == {TB_RED, pins}, "R6 reduced hold", cfg_word, {TB_RED, pins});
    chk(lane_sel_n == 4'hF, "R2 no late mux", 64'(lane_sel_n), 64'hF);
  endtask

  task automatic t_bad(input logic [2:0] code);
    resp_on = 1'b0;
    pin_static = 16'hABCD;
    start(code);
    @(negedge clk);
    chk(done == 1'b1, "R8 done", 64'(done), 64'h1);
    chk(src_err == 1'b1, "R8 err", 64'(src_err), 64'h1);
    chk(cfg_word == TB_DEF, "R8 word default", cfg_word, TB_DEF);
    chk(lane_sel_n == 4'hF, "R8 no lanes", 64'(lane_sel_n), 64'hF);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_mux(64'hA1B2_C3D4_E5F6_0718, 1'b0);
    t_mux(64'h0123_4567_89AB_CDEF, 1'b1);
    t_reduced(16'h4E21);
    t_bad(3'b001);
    t_bad(3'b111);
    t_reset_state();
    t_reduced(16'h00F0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule